// File: doc/BRIEF.md
# Dual-Line Serial Flash Read Controller

This block sits on the host side of a serial flash bus and performs one kind of access: a fast read in which the address and the returned data use two data lines at once. A single-cycle start pulse supplies a 24-bit byte address, a byte count and the serial clock idle level. The controller then pulls chip select low and shifts out an 8-bit read opcode on line 0 alone. It sends the address two bits per serial clock, runs a set number of dummy clocks while it releases both lines, and collects data two bits per clock. Each complete byte goes out on a valid/ready stream. The serial clock comes from the system clock, and each half period lasts a whole number of system clock cycles.

The output stream holds one byte. Once `rd_valid_o` is high, the byte and the valid flag stay unchanged until the consumer takes the byte by asserting `rd_ready_i` in the same cycle. The consumer may hold ready low for any length of time. While it does, the controller parks the serial clock low just before the rising edge that would complete the next byte, and chip select stays low. Because of this, no byte is dropped and no byte is overwritten. Chip select rises half a serial period after the last requested byte has been sampled, even if that byte still waits in the output register.

Top module: `dual_io_flash_reader`

## Requirements
- R1: A start pulse seen while idle with a non-zero byte count makes `busy_o` high and `cs_n_o` low on the next cycle. A start pulse with a count of zero is ignored, and `busy_o` stays low.
- R2: The serial clock idle level is taken from `mode3_i` at the start (0 = idle low, 1 = idle high). It is the `sclk_o` level when chip select falls and after chip select rises. While chip select stays high, `sclk_o` does not change.
- R3: The first 8 serial clocks carry the opcode (default 8'hBB), most significant bit first, on `dq_o[0]`, with `dq_oe_o` = 2'b01.
- R4: The next 12 serial clocks carry the address with `dq_oe_o` = 2'b11. In each clock `dq_o[1]` holds the odd bit and `dq_o[0]` holds the even bit below it, starting with bits 23 and 22.
- R5: `DUMMY_CLKS` clocks (default 8) follow the address. `dq_oe_o` is 2'b00 from the falling edge that begins the first dummy clock until chip select rises. When chip select is high, neither line is driven.
- R6: After the dummy clocks, data is sampled on rising edges of `sclk_o`, four clocks per byte. `dq_i[1]` gives bits 7, 5, 3, 1 and `dq_i[0]` gives bits 6, 4, 2, 0, in that order. Exactly the requested number of bytes reaches the stream, in address order.
- R7: A byte on the stream stays valid and stable until it is accepted. While the consumer withholds ready, the controller holds `sclk_o` low and chip select low before the rising edge that would complete a further byte, and every byte is delivered once ready returns.
- R8: Chip select rises `CLK_DIV` system cycles after the last rising edge, and `busy_o` falls in the same cycle.
- R9: A start pulse while busy has no effect: the running transfer keeps its address and byte count, and no second transfer follows.
- R10: Each half period of `sclk_o` lasts `CLK_DIV` system clock cycles when no stall is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 24 | Start byte address, taken with the request |
| len_i | input | LEN_W | Number of bytes to read, taken with the request |
| mode3_i | input | 1 | Serial clock idle level for this read, taken with the request |
| busy_o | output | 1 | High from an accepted request until chip select rises |
| sclk_o | output | 1 | Serial clock to the flash |
| cs_n_o | output | 1 | Active-low chip select |
| dq_o | output | 2 | Values driven on data lines 1 and 0 |
| dq_oe_o | output | 2 | Per-line output enable for `dq_o` |
| dq_i | input | 2 | Values read from data lines 1 and 0 |
| rd_data_o | output | 8 | Assembled data byte |
| rd_valid_o | output | 1 | Stream valid |
| rd_ready_i | input | 1 | Stream ready |

## Verification
The hardest case to reach is the stall: it only occurs when a byte is still waiting on the stream and the serial clock has reached the low half of the last bit pair of the next byte. Random ready patterns hit it only briefly. So the stimulus includes a directed read in which ready is held low for hundreds of cycles, and the bench checks that the clock is parked low with chip select held before it lets the stream drain. A second case is a start pulse landing in the middle of a transfer. A directed read pulses start with a different address during the opcode phase, then checks the captured address, the byte count and that the controller returns to idle.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_FINISH
  } rd_phase_t;

  localparam int unsigned ADDR_BITS  = 24;
  localparam int unsigned CMD_BITS   = 8;
  localparam int unsigned ADDR_CLKS  = ADDR_BITS / 2;
  localparam int unsigned BYTE_PAIRS = 4;

endpackage

// File: rtl/flash_sclk_tick.sv
module flash_sclk_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic pause_i,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (!pause_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick_o = run_i && !pause_i && (cnt_q == LAST);

endmodule

// File: rtl/flash_rx_buf.sv
module flash_rx_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  input  logic       ready_i
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (push_i) begin
      data_o  <= data_i;
      valid_o <= 1'b1;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
  import flash_rd_pkg::*;
#(
  parameter int unsigned DUMMY_CLKS = 8,
  parameter logic [7:0]  OPCODE     = 8'hBB,
  parameter int unsigned LEN_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_BITS-1:0] addr_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic                 mode3_i,
  input  logic                 tick_i,
  output logic                 run_o,
  output logic                 hold_o,
  output logic                 busy_o,
  output logic                 sclk_o,
  output logic                 cs_n_o,
  output logic [1:0]           dq_o,
  output logic [1:0]           dq_oe_o,
  input  logic [1:0]           dq_i,
  output logic                 push_o,
  output logic [7:0]           byte_o,
  input  logic                 buf_full_i,
  input  logic                 buf_ready_i
);

  localparam int unsigned MAXC  = (DUMMY_CLKS > ADDR_CLKS) ? DUMMY_CLKS : ADDR_CLKS;
  localparam int unsigned CNT_W = $clog2(MAXC);
  localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_CLKS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);
  localparam logic [CNT_W-1:0] PAIR_LAST  = CNT_W'(BYTE_PAIRS - 1);

  rd_phase_t             phase_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  sclk_q;
  logic                  mode_q;
  logic [CMD_BITS-1:0]   cmd_sh_q;
  logic [ADDR_BITS-1:0]  addr_sh_q;
  logic [5:0]            rx_sh_q;
  logic [LEN_W-1:0]      left_q;
  logic                  last_pair;
  logic                  rise_now;

  assign last_pair = (cnt_q == PAIR_LAST);
  assign rise_now  = tick_i && !sclk_q;
  assign hold_o    = (phase_q == PH_DATA) && !sclk_q && last_pair && buf_full_i && !buf_ready_i;
  assign run_o     = (phase_q != PH_IDLE);
  assign busy_o    = run_o;
  assign cs_n_o    = !run_o;
  assign sclk_o    = sclk_q;
  assign push_o    = (phase_q == PH_DATA) && rise_now && last_pair;
  assign byte_o    = {rx_sh_q, dq_i};

  always_comb begin
    dq_o    = 2'b00;
    dq_oe_o = 2'b00;
    case (phase_q)
      PH_SETUP, PH_CMD: begin
        dq_o    = {1'b0, cmd_sh_q[CMD_BITS-1]};
        dq_oe_o = 2'b01;
      end
      PH_ADDR: begin
        dq_o    = addr_sh_q[ADDR_BITS-1 -: 2];
        dq_oe_o = 2'b11;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      sclk_q    <= 1'b0;
      mode_q    <= 1'b0;
      cmd_sh_q  <= '0;
      addr_sh_q <= '0;
      rx_sh_q   <= '0;
      left_q    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start_i && (len_i != '0)) begin
            phase_q   <= PH_SETUP;
            cnt_q     <= '0;
            sclk_q    <= mode3_i;
            mode_q    <= mode3_i;
            cmd_sh_q  <= OPCODE;
            addr_sh_q <= addr_i;
            left_q    <= len_i;
          end
        end
        PH_SETUP: begin
          if (tick_i) begin
            sclk_q  <= 1'b0;
            phase_q <= PH_CMD;
          end
        end
        PH_FINISH: begin
          if (tick_i) begin
            sclk_q  <= mode_q;
            phase_q <= PH_IDLE;
          end
        end
        default: begin
          if (tick_i && !sclk_q) begin
            sclk_q <= 1'b1;
            if (phase_q == PH_DATA) begin
              rx_sh_q <= {rx_sh_q[3:0], dq_i};
              if (last_pair) begin
                left_q <= left_q - LEN_W'(1);
                if (left_q == LEN_W'(1)) phase_q <= PH_FINISH;
              end
            end
          end else if (tick_i) begin
            sclk_q <= 1'b0;
            case (phase_q)
              PH_CMD: begin
                if (cnt_q == CMD_LAST) begin
                  phase_q <= PH_ADDR;
                  cnt_q   <= '0;
                end else begin
                  cmd_sh_q <= {cmd_sh_q[CMD_BITS-2:0], 1'b0};
                  cnt_q    <= cnt_q + CNT_W'(1);
                end
              end
              PH_ADDR: begin
                if (cnt_q == ADDR_LAST) begin
                  phase_q <= PH_DUMMY;
                  cnt_q   <= '0;
                end else begin
                  addr_sh_q <= {addr_sh_q[ADDR_BITS-3:0], 2'b00};
                  cnt_q     <= cnt_q + CNT_W'(1);
                end
              end
              PH_DUMMY: begin
                if (cnt_q == DUMMY_LAST) begin
                  phase_q <= PH_DATA;
                  cnt_q   <= '0;
                end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
                end
              end
              PH_DATA: begin
                cnt_q <= last_pair ? '0 : cnt_q + CNT_W'(1);
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dual_io_flash_reader.sv
module dual_io_flash_reader #(
  parameter int unsigned CLK_DIV    = 2,
  parameter int unsigned DUMMY_CLKS = 8,
  parameter logic [7:0]  OPCODE     = 8'hBB,
  parameter int unsigned LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             mode3_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic [1:0]       dq_o,
  output logic [1:0]       dq_oe_o,
  input  logic [1:0]       dq_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i
);

  logic       seq_run;
  logic       seq_hold;
  logic       half_tick;
  logic       byte_push;
  logic [7:0] byte_val;

  flash_sclk_tick #(
    .DIV (CLK_DIV)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (seq_run),
    .pause_i (seq_hold),
    .tick_o  (half_tick)
  );

  flash_rd_seq #(
    .DUMMY_CLKS (DUMMY_CLKS),
    .OPCODE     (OPCODE),
    .LEN_W      (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .len_i       (len_i),
    .mode3_i     (mode3_i),
    .tick_i      (half_tick),
    .run_o       (seq_run),
    .hold_o      (seq_hold),
    .busy_o      (busy_o),
    .sclk_o      (sclk_o),
    .cs_n_o      (cs_n_o),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .dq_i        (dq_i),
    .push_o      (byte_push),
    .byte_o      (byte_val),
    .buf_full_i  (rd_valid_o),
    .buf_ready_i (rd_ready_i)
  );

  flash_rx_buf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (byte_push),
    .data_i  (byte_val),
    .data_o  (rd_data_o),
    .valid_o (rd_valid_o),
    .ready_i (rd_ready_i)
  );

endmodule

// File: rtl/flash_rd_chk.sv
module flash_rd_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [LEN_W-1:0] len_i,
  input logic             busy_o,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic [1:0]       dq_oe_o,
  input logic [7:0]       rd_data_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic             hold_i
);

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (len_i != '0)) |=> (busy_o && !cs_n_o));

  assert_zero_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (len_i == '0)) |=> !busy_o);

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o)) |-> $stable(sclk_o));

  assert_idle_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (dq_oe_o == 2'b00));

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_clock_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(sclk_o) && !cs_n_o));

endmodule

bind dual_io_flash_reader flash_rd_chk #(
  .LEN_W (LEN_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .len_i      (len_i),
  .busy_o     (busy_o),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .dq_oe_o    (dq_oe_o),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .hold_i     (seq_hold)
);

// File: tb/dual_io_flash_reader_tb.sv
`timescale 1ns/1ps
module dual_io_flash_reader_tb_top;

  localparam int unsigned DIV = 2;
  localparam int unsigned DUM = 8;
  localparam int unsigned LW  = 16;
  localparam logic [7:0]  OP  = 8'hBB;
  localparam int DATA0 = 20 + DUM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0;
  logic [23:0]   addr = '0;
  logic [LW-1:0] len = '0;
  logic          mode3 = 1'b0;
  logic          busy, sclk, cs_n, rd_valid;
  logic          rd_ready = 1'b0;
  logic [1:0]    dq_o, dq_oe;
  logic [1:0]    dq_i = 2'b00;
  logic [7:0]    rd_data;

  dual_io_flash_reader #(
    .CLK_DIV (DIV), .DUMMY_CLKS (DUM), .OPCODE (OP), .LEN_W (LW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start), .addr_i (addr), .len_i (len),
    .mode3_i (mode3), .busy_o (busy), .sclk_o (sclk), .cs_n_o (cs_n),
    .dq_o (dq_o), .dq_oe_o (dq_oe), .dq_i (dq_i), .rd_data_o (rd_data),
    .rd_valid_o (rd_valid), .rd_ready_i (rd_ready)
  );

  int checks = 0;
  int fails  = 0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h3C;
  endfunction

  // flash model and bus monitor
  int          r = 0;
  bit          prev_sclk = 1'b0, prev_cs = 1'b1;
  bit          cmd_bad, addr_oe_bad, dum_bad;
  logic [23:0] cap_addr = '0;
  longint      t1, t2, last_rise, end_gap;
  bit          busy_at_end;
  int          ready_mode = 2;
  logic [7:0]  rx [0:63];
  int          rx_n = 0;

  always @(negedge clk) begin
    cyc++;
    if (!cs_n && prev_cs) begin
      r = 0; cmd_bad = 0; addr_oe_bad = 0; dum_bad = 0;
    end
    if (sclk && !prev_sclk && !cs_n && !prev_cs) begin
      if (r < 8) begin
        if (dq_oe !== 2'b01 || dq_o[0] !== OP[7-r]) cmd_bad = 1;
      end else if (r < 20) begin
        if (dq_oe !== 2'b11) addr_oe_bad = 1;
        cap_addr[23-2*(r-8)] = dq_o[1];
        cap_addr[22-2*(r-8)] = dq_o[0];
      end else begin
        if (dq_oe !== 2'b00) dum_bad = 1;
      end
      if (r == 1) t1 = cyc;
      if (r == 2) t2 = cyc;
      last_rise = cyc;
      r++;
    end
    if (cs_n && !prev_cs) begin
      end_gap = cyc - last_rise;
      busy_at_end = busy;
    end
    if (!cs_n && r >= DATA0) begin
      automatic int k = r - DATA0;
      automatic logic [7:0] b = mem_byte(cap_addr + 24'(k / 4));
      automatic int p = k % 4;
      dq_i = {b[7-2*p], b[6-2*p]};
    end else begin
      dq_i = 2'b00;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
    case (ready_mode)
      0: rd_ready = 1'b0;
      1: rd_ready = $urandom_range(0, 1) == 1;
      default: rd_ready = 1'b1;
    endcase
    if (rd_valid && rd_ready && rx_n < 64) begin
      rx[rx_n] = rd_data;
      rx_n++;
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_xfer(input logic [23:0] a, input int n, input bit m,
                          input int rm, input bit inject, input int hold_cyc);
    int bad;
    rx_n = 0;
    ready_mode = (hold_cyc > 0) ? 0 : rm;
    @(negedge clk);
    start = 1'b1; addr = a; len = LW'(n); mode3 = m;
    @(negedge clk);
    start = 1'b0; addr = ~a; mode3 = ~m;
    chk(busy && !cs_n, "R1 accept", {busy, cs_n}, 2'b10);
    chk(sclk == m, "R2 level at select", sclk, m);
    if (inject) begin
      repeat (30) @(negedge clk);
      start = 1'b1; addr = ~a; len = LW'(1);
      @(negedge clk);
      start = 1'b0;
    end
    if (hold_cyc > 0) begin
      repeat (hold_cyc) @(negedge clk);
      chk(busy && !cs_n && !sclk && rd_valid && rd_data == mem_byte(a) && rx_n == 0,
          "R7 parked", {busy, cs_n, sclk, rd_valid, rd_data}, {4'b1001, mem_byte(a)});
      ready_mode = rm;
    end
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    ready_mode = 2;
    for (int i = 0; i < 200 && rx_n < n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!cmd_bad, "R3 opcode", cmd_bad, 0);
    chk(cap_addr == a && !addr_oe_bad, "R4 address", cap_addr, a);
    chk(!dum_bad, "R5 release", dum_bad, 0);
    bad = 0;
    for (int i = 0; i < n && i < rx_n; i++)
      if (rx[i] != mem_byte(a + 24'(i))) bad++;
    chk(rx_n == n && bad == 0, "R6 data", rx_n, n);
    chk(end_gap == DIV && !busy_at_end, "R8 end", end_gap, DIV);
    chk(t2 - t1 == 2 * DIV, "R10 period", t2 - t1, 2 * DIV);
    chk(!busy && cs_n && sclk == m, "R2 idle level", {busy, cs_n, sclk}, {2'b01, m});
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    chk(cs_n && !busy && !rd_valid && dq_oe == 2'b00 && !sclk, "reset state",
        {cs_n, busy, rd_valid, dq_oe, sclk}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: zero count ignored
    @(negedge clk);
    start = 1'b1; len = '0; addr = 24'h123456;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && cs_n, "R1 zero count", {busy, cs_n}, 2'b01);

    run_xfer(24'hA5C3F0, 4, 1'b0, 2, 1'b0, 0);
    run_xfer(24'h0F0F0F, 3, 1'b1, 2, 1'b0, 0);
    // R9: start while busy ignored
    run_xfer(24'h5A5A01, 2, 1'b0, 2, 1'b1, 0);
    // R7: long stall with the clock parked
    run_xfer(24'h3300FE, 3, 1'b0, 1, 1'b0, 600);
    run_xfer(24'hFFFFFE, 1, 1'b1, 2, 1'b0, 0);

    for (int t = 0; t < 12; t++) begin
      run_xfer(24'($urandom), $urandom_range(1, 12), 1'($urandom_range(0, 1)),
               $urandom_range(1, 2), 1'b0, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule